// File: doc/BRIEF.md
# Migrated Block Tag Table

Each tile of a tiled multiprocessor keeps a small set-associative table recording where migrated cache blocks currently sit. Two kinds of entry share the table. A local entry belongs to a block whose home is this tile but which has moved to another tile. A remote entry caches the current host of a block homed elsewhere that this tile has recently touched. Before a request is sent to the home tile, the requesting tile checks this table. On a hit, the request goes straight to the recorded host. On a miss, the home tile forwards the request, and the requester later installs a remote entry.

Every local entry keeps a per-tile sharer mask with one bit for each tile that holds a remote copy of that entry. The table raises a notification carrying this mask when the host of a local block moves or when the local entry is invalidated. In both cases the remote copies elsewhere can then be corrected.

Replacement picks an invalid way first. If there is no invalid way, it evicts the least recently used remote entry. A local entry is never evicted. When a set holds only local entries, an insert into that set is refused.

Top module: `mbt_table`

## Requirements
- R1: A request accepted on one clock edge gives `rsp_valid` high for exactly that one following cycle, and `rsp_valid` stays low in a cycle after an idle one. Opcodes: 0 lookup, 1 remote insert, 2 local insert, 3 invalidate.
- R2: A lookup reports `rsp_hit` high when the table holds a valid entry with that address. On a hit it also reports the stored host on `rsp_host` and the entry kind on `rsp_local` (1 = local).
- R3: A remote insert of an address that is not present allocates a remote entry. A remote insert of an address already held as a remote entry replaces its host and reports `rsp_hit`.
- R4: A local insert of an address that is not present allocates a local entry with an empty sharer mask.
- R5: A lookup that hits a local entry sets bit `req_src` (bit n = tile n) in that entry's sharer mask.
- R6: A local insert that hits a local entry with a different host and a nonzero mask raises `ntf_valid` with `ntf_inval` low, the old mask and the new host. It then clears the mask. With the same host, or with an empty mask, no notification is raised and the mask is kept.
- R7: An invalidate removes the matching entry. If that entry was local with a nonzero mask, the table raises `ntf_valid` with `ntf_inval` high and the mask.
- R8: Allocation uses the lowest-numbered invalid way first. If every way is valid, it evicts the least recently used remote entry. Lookup hits and inserts make the entry most recently used.
- R9: If every way of the set holds a local entry, an insert of a new address is refused with `rsp_reject` and the table is unchanged.
- R10: A remote insert whose address matches a local entry is refused with `rsp_reject` and `rsp_hit`, and the local entry is left unchanged.
- R11: A synchronous reset empties the table and clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Opcode (0 lookup, 1 remote insert, 2 local insert, 3 invalidate) |
| req_addr | input | ADDR_W | Block address; low bits select the set |
| req_host | input | HOST_W | Host tile for inserts |
| req_src | input | HOST_W | Tile issuing a lookup, recorded as sharer |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Address matched a valid entry |
| rsp_local | output | 1 | Matched entry is local |
| rsp_host | output | HOST_W | Host of the matched entry |
| rsp_reject | output | 1 | Insert refused |
| ntf_valid | output | 1 | Sharer notification strobe |
| ntf_inval | output | 1 | 1 = invalidate copies, 0 = update host |
| ntf_addr | output | ADDR_W | Block address of the notification |
| ntf_mask | output | TILES | Tiles to notify |
| ntf_host | output | HOST_W | New host (update) or last host (invalidate) |

## Verification
Several properties are checked on every request cycle. At most one way matches an address. The age values of the addressed set always form a permutation. The chosen victim is never a valid local entry. Responses follow requests by exactly one cycle, and every notification carries a nonzero mask. Other behaviour shows only through directed sequences: the order in which remote entries are evicted, sharer bits accumulating across lookups and being cleared by a host move, refusal in an all-local set, and the table being emptied by reset.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP     = 2'd0,
    OP_INS_REMOTE = 2'd1,
    OP_INS_LOCAL  = 2'd2,
    OP_INVAL      = 2'd3
  } mbt_op_e;
endpackage

// File: rtl/mbt_victim.sv
// Victim choice: lowest invalid way, else the oldest remote way (R8).
module mbt_victim #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0]            loc_e,
  input  logic [WAYS-1:0][AGE_W-1:0] age,
  output logic                       found,
  output logic [AGE_W-1:0]           way
);
  logic             inv_found, rem_found;
  logic [AGE_W-1:0] inv_way, rem_way, rem_age;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        inv_found = 1'b1;
        inv_way   = AGE_W'(w);
      end
    end
    rem_found = 1'b0;
    rem_way   = '0;
    rem_age   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid[w] && !loc_e[w] && (!rem_found || age[w] > rem_age)) begin
        rem_found = 1'b1;
        rem_way   = AGE_W'(w);
        rem_age   = age[w];
      end
    end
    found = inv_found | rem_found;
    way   = inv_found ? inv_way : rem_way;
  end
endmodule

// File: rtl/mbt_lru_update.sv
// Age update: touched way becomes 0, younger ways age by one.
module mbt_lru_update #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0][AGE_W-1:0] age_in,
  input  logic [AGE_W-1:0]           touch,
  output logic [WAYS-1:0][AGE_W-1:0] age_out
);
  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign age_out[w] = (AGE_W'(w) == touch) ? '0 :
                        (age_in[w] < age_in[touch]) ? age_in[w] + 1'b1 : age_in[w];
  end
endmodule

// File: rtl/mbt_table.sv
module mbt_table
  import mbt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TILES  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [1:0]                    req_op,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [$clog2(TILES)-1:0]      req_host,
  input  logic [$clog2(TILES)-1:0]      req_src,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic                          rsp_local,
  output logic [$clog2(TILES)-1:0]      rsp_host,
  output logic                          rsp_reject,
  output logic                          ntf_valid,
  output logic                          ntf_inval,
  output logic [ADDR_W-1:0]             ntf_addr,
  output logic [TILES-1:0]              ntf_mask,
  output logic [$clog2(TILES)-1:0]      ntf_host
);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int AGE_W  = $clog2(WAYS);
  localparam int HOST_W = $clog2(TILES);

  // Storage
  logic [WAYS-1:0]            v_q   [SETS];
  logic [WAYS-1:0]            l_q   [SETS];
  logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
  logic [TAG_W-1:0]           tag_q [SETS][WAYS];
  logic [HOST_W-1:0]          host_q[SETS][WAYS];
  logic [TILES-1:0]           mask_q[SETS][WAYS];

  logic [SET_W-1:0] set_i;
  logic [TAG_W-1:0] tag_i;
  mbt_op_e          op;
  assign set_i = req_addr[SET_W-1:0];
  assign tag_i = req_addr[ADDR_W-1:SET_W];
  assign op    = mbt_op_e'(req_op);

  // Set read and tag compare
  logic [WAYS-1:0]            hit_vec, loc_rd;
  logic [WAYS-1:0][AGE_W-1:0] age_rd, age_new;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = v_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    assign loc_rd[w]  = l_q[set_i][w];
    assign age_rd[w]  = age_q[set_i][w];
  end

  logic             hit_any;
  logic [AGE_W-1:0] hit_way;
  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_any = 1'b1;
        hit_way = AGE_W'(w);
      end
    end
  end

  logic [HOST_W-1:0] hit_host;
  logic [TILES-1:0]  hit_mask;
  logic              hit_loc;
  assign hit_host = host_q[set_i][hit_way];
  assign hit_mask = mask_q[set_i][hit_way];
  assign hit_loc  = loc_rd[hit_way];

  logic             vic_ok;
  logic [AGE_W-1:0] vic_way;
  mbt_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
    .valid(v_q[set_i]), .loc_e(loc_rd), .age(age_rd),
    .found(vic_ok), .way(vic_way)
  );

  logic             touch_en;
  logic [AGE_W-1:0] touch_way;
  mbt_lru_update #(.WAYS(WAYS), .AGE_W(AGE_W)) u_lru (
    .age_in(age_rd), .touch(touch_way), .age_out(age_new)
  );

  // Decision
  logic              ent_wr, ent_valid, ent_loc, mask_wr;
  logic [AGE_W-1:0]  ent_way;
  logic [HOST_W-1:0] ent_host;
  logic [TILES-1:0]  mask_val;
  logic              o_hit, o_loc, o_rej, n_valid, n_inval;
  logic [HOST_W-1:0] o_host, n_host;
  logic [TILES-1:0]  n_mask;

  always_comb begin
    ent_wr = 1'b0; ent_valid = 1'b0; ent_loc = 1'b0; ent_way = hit_way; ent_host = req_host;
    mask_wr = 1'b0; mask_val = '0;
    touch_en = 1'b0; touch_way = hit_way;
    o_hit = hit_any; o_loc = hit_any & hit_loc; o_host = hit_any ? hit_host : '0; o_rej = 1'b0;
    n_valid = 1'b0; n_inval = 1'b0; n_mask = hit_mask; n_host = req_host;
    if (req_valid) begin
      unique case (op)
        OP_LOOKUP: begin
          if (hit_any) begin
            touch_en = 1'b1;
            if (hit_loc) begin
              mask_wr  = 1'b1;
              mask_val = hit_mask | (TILES'(1) << req_src);
            end
          end
        end
        OP_INS_REMOTE, OP_INS_LOCAL: begin
          if (hit_any) begin
            if (op == OP_INS_REMOTE && hit_loc) begin
              o_rej = 1'b1;
            end else begin
              touch_en  = 1'b1;
              ent_wr    = 1'b1;
              ent_valid = 1'b1;
              ent_loc   = (op == OP_INS_LOCAL);
              if (op == OP_INS_LOCAL && hit_loc) begin
                if (hit_host != req_host && hit_mask != '0) begin
                  n_valid  = 1'b1;
                  mask_wr  = 1'b1;
                  mask_val = '0;
                end
              end else begin
                mask_wr  = 1'b1;
                mask_val = '0;
              end
            end
          end else if (vic_ok) begin
            touch_en  = 1'b1;
            touch_way = vic_way;
            ent_wr    = 1'b1;
            ent_way   = vic_way;
            ent_valid = 1'b1;
            ent_loc   = (op == OP_INS_LOCAL);
            mask_wr   = 1'b1;
            mask_val  = '0;
          end else begin
            o_rej = 1'b1;
          end
        end
        OP_INVAL: begin
          if (hit_any) begin
            ent_wr    = 1'b1;
            ent_valid = 1'b0;
            ent_loc   = hit_loc;
            ent_host  = hit_host;
            n_host    = hit_host;
            if (hit_loc && hit_mask != '0) begin
              n_valid = 1'b1;
              n_inval = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // State with reset: valid bits and ages
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else begin
      if (ent_wr)   v_q[set_i][ent_way] <= ent_valid;
      if (touch_en) age_q[set_i] <= age_new;
    end
  end

  // Payload arrays, no reset
  always_ff @(posedge clk) begin
    if (ent_wr && !rst) begin
      l_q[set_i][ent_way]    <= ent_loc;
      tag_q[set_i][ent_way]  <= tag_i;
      host_q[set_i][ent_way] <= ent_host;
    end
  end

  always_ff @(posedge clk) begin
    if (mask_wr && !rst) mask_q[set_i][ent_way] <= mask_val;
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_local <= 1'b0; rsp_host <= '0; rsp_reject <= 1'b0;
      ntf_valid <= 1'b0; ntf_inval <= 1'b0; ntf_addr <= '0; ntf_mask <= '0; ntf_host <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid & o_hit;
      rsp_local  <= req_valid & o_loc;
      rsp_host   <= req_valid ? o_host : '0;
      rsp_reject <= o_rej;
      ntf_valid  <= n_valid;
      ntf_inval  <= n_valid & n_inval;
      ntf_addr   <= n_valid ? req_addr : '0;
      ntf_mask   <= n_valid ? n_mask : '0;
      ntf_host   <= n_valid ? n_host : '0;
    end
  end

  // Assertions
  function automatic logic ages_perm(input logic [WAYS-1:0][AGE_W-1:0] a);
    logic [WAYS-1:0] seen;
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[a[w]] = 1'b1;
    return &seen;
  endfunction

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_idle_no_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_single_match_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(hit_vec));
  p_ntf_mask_set_r6: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> (ntf_mask != '0) && rsp_valid);
  p_ages_perm_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ages_perm(age_rd));
  p_victim_not_local_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && vic_ok) |-> !(v_q[set_i][vic_way] && loc_rd[vic_way]));
  p_reject_with_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_reject |-> rsp_valid);
endmodule

// File: tb/mbt_table_test.sv
module mbt_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int TILES  = 16;
  localparam int HOST_W = 4;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic [15:0] addr;
    logic [3:0]  host;
    logic [3:0]  src;
    logic        hit;
    logic        loc;
    logic [3:0]  ehost;
    logic        rej;
    logic        ntf;
    logic        inv;
    logic [15:0] mask;
  } vec_t;

  function automatic vec_t mkv(input int r, input int op, input int addr, input int host,
      input int src, input int hit, input int loc, input int ehost, input int rej,
      input int ntf, input int inv, input int mask);
    vec_t v;
    v.req = 4'(r); v.op = 2'(op); v.addr = 16'(addr); v.host = 4'(host); v.src = 4'(src);
    v.hit = 1'(hit); v.loc = 1'(loc); v.ehost = 4'(ehost); v.rej = 1'(rej);
    v.ntf = 1'(ntf); v.inv = 1'(inv); v.mask = 16'(mask);
    return v;
  endfunction

  localparam int NV = 43;
  // fields: req, op, addr, host, src | hit, loc, host, reject, ntf, inval, mask
  localparam vec_t VEC [NV] = '{
    mkv(2, 0, 'h0011, 0, 0,  0,0,0,0,0,0,0),       // R2 miss
    mkv(3, 1, 'h0011, 5, 0,  0,0,0,0,0,0,0),       // R3 install remote
    mkv(2, 0, 'h0011, 0, 0,  1,0,5,0,0,0,0),       // R2 hit
    mkv(4, 2, 'h0021, 7, 0,  0,0,0,0,0,0,0),       // R4 install local
    mkv(5, 0, 'h0021, 0, 3,  1,1,7,0,0,0,0),       // R5 sharer 3
    mkv(5, 0, 'h0021, 0, 9,  1,1,7,0,0,0,0),       // R5 sharer 9
    mkv(6, 2, 'h0021, 2, 0,  1,0,0,0,1,0,'h0208),  // R6 update notice
    mkv(6, 2, 'h0021, 4, 0,  1,0,0,0,0,0,0),       // R6 mask cleared
    mkv(5, 0, 'h0021, 0, 1,  1,1,4,0,0,0,0),       // R5 sharer 1
    mkv(6, 2, 'h0021, 4, 0,  1,0,0,0,0,0,0),       // R6 same host
    mkv(7, 3, 'h0021, 0, 0,  1,0,0,0,1,1,'h0002),  // R7 inval notice
    mkv(7, 0, 'h0021, 0, 0,  0,0,0,0,0,0,0),       // R7 gone
    mkv(3, 1, 'h0011, 9, 0,  1,0,0,0,0,0,0),       // R3 host update
    mkv(3, 0, 'h0011, 0, 0,  1,0,9,0,0,0,0),       // R3 new host
    mkv(8, 1, 'h0012, 1, 0,  0,0,0,0,0,0,0),       // R8 fill
    mkv(8, 1, 'h0022, 2, 0,  0,0,0,0,0,0,0),
    mkv(8, 1, 'h0032, 3, 0,  0,0,0,0,0,0,0),
    mkv(8, 1, 'h0042, 4, 0,  0,0,0,0,0,0,0),
    mkv(8, 0, 'h0012, 0, 0,  1,0,1,0,0,0,0),       // R8 refresh
    mkv(8, 1, 'h0052, 5, 0,  0,0,0,0,0,0,0),       // R8 evict LRU remote
    mkv(8, 0, 'h0022, 0, 0,  0,0,0,0,0,0,0),       // R8 victim gone
    mkv(8, 0, 'h0032, 0, 0,  1,0,3,0,0,0,0),
    mkv(8, 0, 'h0052, 0, 0,  1,0,5,0,0,0,0),
    mkv(9, 2, 'h0013, 1, 0,  0,0,0,0,0,0,0),       // R9 fill locals
    mkv(9, 2, 'h0023, 2, 0,  0,0,0,0,0,0,0),
    mkv(9, 2, 'h0033, 3, 0,  0,0,0,0,0,0,0),
    mkv(9, 2, 'h0043, 4, 0,  0,0,0,0,0,0,0),
    mkv(9, 1, 'h0053, 5, 0,  0,0,0,1,0,0,0),       // R9 reject remote
    mkv(9, 0, 'h0053, 0, 0,  0,0,0,0,0,0,0),
    mkv(9, 2, 'h0053, 6, 0,  0,0,0,1,0,0,0),       // R9 reject local
    mkv(9, 0, 'h0013, 0, 0,  1,1,1,0,0,0,0),       // R9 unchanged
    mkv(8, 1, 'h0014, 1, 0,  0,0,0,0,0,0,0),       // R8 mixed set
    mkv(8, 2, 'h0024, 2, 0,  0,0,0,0,0,0,0),
    mkv(8, 2, 'h0034, 3, 0,  0,0,0,0,0,0,0),
    mkv(8, 2, 'h0044, 4, 0,  0,0,0,0,0,0,0),
    mkv(8, 0, 'h0014, 0, 0,  1,0,1,0,0,0,0),       // R8 remote is MRU
    mkv(8, 1, 'h0054, 6, 0,  0,0,0,0,0,0,0),       // R8 still evicts remote
    mkv(8, 0, 'h0014, 0, 0,  0,0,0,0,0,0,0),
    mkv(8, 0, 'h0024, 0, 0,  1,1,2,0,0,0,0),
    mkv(10, 1, 'h0024, 9, 0, 1,0,0,1,0,0,0),       // R10 reject on local
    mkv(10, 0, 'h0024, 0, 0, 1,1,2,0,0,0,0),       // R10 unchanged
    mkv(7, 3, 'h0034, 0, 0,  1,0,0,0,0,0,0),       // R7 no mask, no notice
    mkv(7, 0, 'h0034, 0, 0,  0,0,0,0,0,0,0)
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [HOST_W-1:0] req_host = '0;
  logic [HOST_W-1:0] req_src = '0;
  logic              rsp_valid, rsp_hit, rsp_local, rsp_reject, ntf_valid, ntf_inval;
  logic [HOST_W-1:0] rsp_host, ntf_host;
  logic [ADDR_W-1:0] ntf_addr;
  logic [TILES-1:0]  ntf_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbt_table #(.ADDR_W(ADDR_W), .SETS(16), .WAYS(4), .TILES(TILES)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_host(req_host), .req_src(req_src), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_local(rsp_local), .rsp_host(rsp_host), .rsp_reject(rsp_reject),
    .ntf_valid(ntf_valid), .ntf_inval(ntf_inval), .ntf_addr(ntf_addr),
    .ntf_mask(ntf_mask), .ntf_host(ntf_host)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_host = v.host; req_src = v.src;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_host = '0; req_src = '0;
  endtask

  task automatic check_vec(input int i, input vec_t v);
    logic [31:0] act, exp;
    act = {rsp_valid, rsp_hit, rsp_reject, ntf_valid};
    exp = {1'b1, v.hit, v.rej, v.ntf};
    if (v.op == 2'd0) begin
      act = {act[27:0], rsp_local, 3'b0, rsp_host};
      exp = {exp[27:0], v.loc, 3'b0, v.ehost};
    end
    if (v.ntf) begin
      act = {ntf_inval, ntf_mask};
      exp = {v.inv, v.mask};
      check($sformatf("R%0d vec %0d notice", v.req, i), act, exp);
      act = {rsp_valid, rsp_hit, rsp_reject, ntf_valid};
      exp = {1'b1, v.hit, v.rej, v.ntf};
    end
    check($sformatf("R%0d vec %0d", v.req, i), act, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 reset outputs", {rsp_valid, rsp_hit, rsp_reject, ntf_valid, ntf_mask}, '0);
    @(negedge clk);
    // R1 idle gives no response
    check("R1 idle", {31'b0, rsp_valid}, 32'd0);
    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_vec(i, VEC[i]);
      if (i + 1 < NV) drive(VEC[i+1]); else idle();
    end
    @(negedge clk);
    check("R1 single pulse", {31'b0, rsp_valid}, 32'd0);
    // R11 reset empties table (0x0011 was present)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 outputs after reset", {rsp_valid, ntf_valid}, '0);
    drive(mkv(11, 0, 'h0011, 0, 0, 0,0,0,0,0,0,0));
    @(negedge clk);
    check("R11 table empty", {rsp_valid, rsp_hit}, 32'h2);
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule